// File: doc/BRIEF.md
# Interrupt Control Register with Periodic Level-7 Tick

This block holds a 32-bit control register that drives the seven request lines of a processor's interrupt input. A master enable sits in bit 24. Three request bits (25, 26, 27) can raise levels 1, 2 and 3 from software, and a periodic tick gives level 7 a fresh low-then-high edge while both bit 31 and bit 24 are set. An external level-7 source, such as a memory error detector, is merged into the top line.

The tick comes from a prescaler. The `tick_in` strobe is counted, and every `TICK_DIV`-th counted strobe is one tick. Tie `tick_in` high to divide the system clock directly. Set `TICK_DIV` to 1 to pass an external 100 Hz strobe straight through. Software writes through a single-cycle write port with byte enables, and the register contents are always visible on `rd_data`.

Top module: `irq_ctl_tick`

## Requirements
- R1: After reset the register reads 0 and all seven request outputs are low.
- R2: A write updates only the bytes whose enable bit is set (enable bit k covers data bits 8k+7..8k), and the register content appears on `rd_data` one cycle after the write.
- R3: A write that enables byte 3 with bit 24 set raises request level n+1 (output bit n) for each bit 25+n (n = 0..2) set in that write, one cycle after the write.
- R4: Requests at levels 1 to 3 are sticky. A write with bit 24 set and any of bits 25 to 27 clear leaves the already raised levels high.
- R5: A write that enables byte 3 with bit 24 clear lowers levels 1 to 3 and the internal level-7 request one cycle after the write.
- R6: A write that enables byte 3 with bit 24 set and bit 31 clear lowers the internal level-7 request one cycle after the write.
- R7: On a tick while the stored register has bits 31 and 24 both set, level 7 is low in the cycle after the tick and high in the cycle after that. A tick while either bit is clear changes nothing.
- R8: Ticks occur on every `TICK_DIV`-th cycle in which `tick_in` is high. While `tick_in` is low, no tick occurs.
- R9: `ext_l7` high forces level 7 (output bit 6) high in the same cycle, whatever the register holds.
- R10: A write without the byte-3 enable takes no request action. It neither raises nor lowers any level.
- R11: Request levels 4 to 6 (output bits 3 to 5) stay low at all times.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_be | input | 4 | Byte enables for the write |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Current register content |
| tick_in | input | 1 | Strobe counted by the tick prescaler |
| ext_l7 | input | 1 | External level-7 request |
| irq_lvl | output | 7 | Request lines, bit n is level n+1 |

## Verification
Register contents and the level 1 to 3 and level-7 results of a write are due one clock after the write. The bench samples them at the falling edge that follows the capturing rising edge. After a gated tick, level 7 is low one cycle later and high again two cycles later. The bench therefore records level 7 at every falling edge and checks two things: that each low spans exactly one sample, and that successive lows are exactly `TICK_DIV` samples apart. `ext_l7` acts without a register, so the bench checks it in the same cycle it is driven.

// File: rtl/irq_ctl_pkg.sv
package irq_ctl_pkg;
  localparam int REG_W    = 32;
  localparam int LANES    = REG_W / 8;
  localparam int NLEV     = 7;
  localparam int MEN_BIT  = 24;
  localparam int L7EN_BIT = 31;
  localparam int SW_LSB   = 25;
  localparam int SW_N     = 3;
  localparam int CMD_LANE = MEN_BIT / 8;

  typedef struct packed {
    logic            set_sw;
    logic            clr_all;
    logic            clr_l7;
    logic [SW_N-1:0] sw_bits;
  } wr_evt_t;

  // Byte-lane merge of a write into the old register value.
  function automatic logic [REG_W-1:0] merge_lanes(input logic [REG_W-1:0] old_v,
                                                   input logic [REG_W-1:0] new_v,
                                                   input logic [LANES-1:0] be);
    logic [REG_W-1:0] r;
    r = old_v;
    for (int k = 0; k < LANES; k++)
      if (be[k]) r[8*k +: 8] = new_v[8*k +: 8];
    return r;
  endfunction

  // Request actions carried by one write; only the command lane acts.
  function automatic wr_evt_t decode_write(input logic wr,
                                           input logic [LANES-1:0] be,
                                           input logic [REG_W-1:0] d);
    wr_evt_t e;
    logic hit;
    hit       = wr && be[CMD_LANE];
    e.set_sw  = hit && d[MEN_BIT];
    e.clr_all = hit && !d[MEN_BIT];
    e.clr_l7  = hit && (!d[MEN_BIT] || !d[L7EN_BIT]);
    e.sw_bits = e.set_sw ? d[SW_LSB +: SW_N] : '0;
    return e;
  endfunction
endpackage

// File: rtl/irq_tick_div.sv
module irq_tick_div #(
  parameter int unsigned DIV = 200000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_in,
  output logic tick
);
  localparam int CNT_W = (DIV > 1) ? $clog2(DIV) : 1;

  generate
    if (DIV <= 1) begin : g_pass
      assign tick = tick_in;
    end else begin : g_div
      logic [CNT_W-1:0] cnt;
      logic             wrap;
      assign wrap = (cnt == CNT_W'(DIV - 1));
      always_ff @(posedge clk) begin
        if (!rst_n)       cnt <= '0;
        else if (tick_in) cnt <= wrap ? '0 : cnt + 1'b1;
      end
      assign tick = tick_in && wrap;
    end
  endgenerate
endmodule

// File: rtl/irq_ctl_reg.sv
module irq_ctl_reg
  import irq_ctl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [LANES-1:0] wr_be,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] ctrl_q,
  output logic             gate,
  output wr_evt_t          evt
);
  always_ff @(posedge clk) begin
    if (!rst_n)     ctrl_q <= '0;
    else if (wr_en) ctrl_q <= merge_lanes(ctrl_q, wr_data, wr_be);
  end

  assign gate = ctrl_q[L7EN_BIT] && ctrl_q[MEN_BIT];
  assign evt  = decode_write(wr_en, wr_be, wr_data);
endmodule

// File: rtl/irq_req_lines.sv
module irq_req_lines
  import irq_ctl_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  wr_evt_t         evt,
  input  logic            tick_fire,
  input  logic            ext_l7,
  output logic [NLEV-1:0] irq_lvl,
  output logic            arm_o,
  output logic            l7_o
);
  logic [SW_N-1:0] sw_q;
  logic            l7_q, arm_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sw_q  <= '0;
      l7_q  <= 1'b0;
      arm_q <= 1'b0;
    end else begin
      sw_q <= evt.clr_all ? '0 : (sw_q | evt.sw_bits);
      if (evt.clr_l7) begin
        l7_q  <= 1'b0;
        arm_q <= 1'b0;
      end else if (tick_fire) begin
        l7_q  <= 1'b0;
        arm_q <= 1'b1;
      end else if (arm_q) begin
        l7_q  <= 1'b1;
        arm_q <= 1'b0;
      end
    end
  end

  generate
    for (genvar n = 0; n < NLEV; n++) begin : g_lvl
      if (n < SW_N) begin : g_sw
        assign irq_lvl[n] = sw_q[n];
      end else if (n == NLEV - 1) begin : g_top
        assign irq_lvl[n] = l7_q || ext_l7;
      end else begin : g_idle
        assign irq_lvl[n] = 1'b0;
      end
    end
  endgenerate

  assign arm_o = arm_q;
  assign l7_o  = l7_q;
endmodule

// File: rtl/irq_ctl_tick.sv
module irq_ctl_tick
  import irq_ctl_pkg::*;
#(
  parameter int unsigned TICK_DIV = 200000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [3:0]  wr_be,
  input  logic [31:0] wr_data,
  output logic [31:0] rd_data,
  input  logic        tick_in,
  input  logic        ext_l7,
  output logic [6:0]  irq_lvl
);
  logic    tick, gate, tick_fire, arm, l7_int;
  wr_evt_t evt;

  irq_tick_div #(.DIV(TICK_DIV)) u_div (
    .clk(clk), .rst_n(rst_n), .tick_in(tick_in), .tick(tick)
  );

  irq_ctl_reg u_reg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_be(wr_be),
    .wr_data(wr_data), .ctrl_q(rd_data), .gate(gate), .evt(evt)
  );

  assign tick_fire = tick && gate;

  irq_req_lines u_lines (
    .clk(clk), .rst_n(rst_n), .evt(evt), .tick_fire(tick_fire),
    .ext_l7(ext_l7), .irq_lvl(irq_lvl), .arm_o(arm), .l7_o(l7_int)
  );
endmodule

// File: rtl/irq_ctl_tick_chk.sv
module irq_ctl_tick_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       set_sw,
  input logic       clr_all,
  input logic       clr_l7,
  input logic [2:0] sw_bits,
  input logic       tick_fire,
  input logic       arm,
  input logic       l7_int,
  input logic       ext_l7,
  input logic [6:0] irq_lvl
);
  p_mid_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    irq_lvl[5:3] == 3'b000);

  p_ext_merge_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ext_l7 |-> irq_lvl[6]);

  p_sw_raise_r3: assert property (@(posedge clk) disable iff (!rst_n)
    set_sw |=> (($past(sw_bits) & ~irq_lvl[2:0]) == 3'b000));

  p_sw_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_all |=> (($past(irq_lvl[2:0]) & ~irq_lvl[2:0]) == 3'b000));

  p_clear_all_r5: assert property (@(posedge clk) disable iff (!rst_n)
    clr_all |=> (irq_lvl[2:0] == 3'b000 && !l7_int));

  p_clear_top_r6: assert property (@(posedge clk) disable iff (!rst_n)
    clr_l7 |=> !l7_int);

  p_tick_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tick_fire |=> !l7_int);

  p_tick_back_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (arm && !clr_l7) |=> l7_int);
endmodule

bind irq_ctl_tick irq_ctl_tick_chk u_chk (
  .clk(clk), .rst_n(rst_n), .set_sw(evt.set_sw), .clr_all(evt.clr_all),
  .clr_l7(evt.clr_l7), .sw_bits(evt.sw_bits), .tick_fire(tick_fire),
  .arm(arm), .l7_int(l7_int), .ext_l7(ext_l7), .irq_lvl(irq_lvl)
);

// File: tb/irq_ctl_tick_test.sv
module irq_ctl_tick_test;
  localparam int CLK_PERIOD = 10;
  localparam int DIV        = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_be = 4'h0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        tick_in = 1'b1;
  logic        ext_l7 = 1'b0;
  logic [6:0]  irq_lvl;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_ctl_tick #(.TICK_DIV(DIV)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_be(wr_be), .wr_data(wr_data),
    .rd_data(rd_data), .tick_in(tick_in), .ext_l7(ext_l7), .irq_lvl(irq_lvl)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Drive one write at a falling edge; returns at the next falling edge,
  // where the results of the write are visible.
  task automatic wr(input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_be = be; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_be = 4'h0; wr_data = '0;
  endtask

  function automatic logic [31:0] merge(input logic [31:0] o, input logic [31:0] n, input logic [3:0] be);
    logic [31:0] m;
    m = {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}};
    return (o & ~m) | (n & m);
  endfunction

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] model;
    int last_low, lows;
    bit seen_high, prev_low;

    repeat (3) @(negedge clk);
    // R1 reset state
    chk(rd_data == 0, "R1 reg", rd_data, 0);
    chk(irq_lvl == 0, "R1 irq", {25'd0, irq_lvl}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rd_data == 0 && irq_lvl == 0, "R1 after release", {25'd0, irq_lvl}, 0);

    model = 0;
    wr(4'hF, 32'h0300_0000); model = merge(model, 32'h0300_0000, 4'hF);
    chk(rd_data == model, "R2 readback", rd_data, model);
    chk(irq_lvl == 7'b000_0001, "R3 level1", {25'd0, irq_lvl}, 1);

    wr(4'hF, 32'h0500_0000); model = merge(model, 32'h0500_0000, 4'hF);
    chk(irq_lvl == 7'b000_0011, "R3 R4 level2 added", {25'd0, irq_lvl}, 3);

    wr(4'hF, 32'h0100_0000); model = merge(model, 32'h0100_0000, 4'hF);
    chk(irq_lvl == 7'b000_0011, "R4 sticky", {25'd0, irq_lvl}, 3);

    wr(4'h7, 32'h0E00_1234); model = merge(model, 32'h0E00_1234, 4'h7);
    chk(rd_data == model, "R2 partial lanes", rd_data, model);
    chk(irq_lvl == 7'b000_0011, "R10 no lane3 no raise", {25'd0, irq_lvl}, 3);

    wr(4'h7, 32'h0000_0000); model = merge(model, 32'h0, 4'h7);
    chk(irq_lvl == 7'b000_0011, "R10 no lane3 no clear", {25'd0, irq_lvl}, 3);
    chk(rd_data == model, "R2 lower lanes zeroed", rd_data, model);

    wr(4'h8, 32'h0900_5678); model = merge(model, 32'h0900_5678, 4'h8);
    chk(irq_lvl == 7'b000_0111, "R3 level3 via lane3 only", {25'd0, irq_lvl}, 7);
    chk(rd_data == model, "R2 lane3 only", rd_data, model);

    // R9 external request, immune to master enable
    @(negedge clk); ext_l7 = 1'b1; #1;
    chk(irq_lvl[6] == 1'b1, "R9 ext same cycle", {31'd0, irq_lvl[6]}, 1);
    wr(4'h8, 32'h0000_0000); model = merge(model, 32'h0, 4'h8);
    chk(irq_lvl == 7'b100_0000, "R5 R9 clear with ext held", {25'd0, irq_lvl}, 32'h40);
    @(negedge clk); ext_l7 = 1'b0; #1;
    chk(irq_lvl == 0, "R5 all low", {25'd0, irq_lvl}, 0);

    // Sweep of the three software bits
    for (int v = 0; v < 8; v++) begin
      wr(4'hF, 32'h0000_0000);
      wr(4'hF, (32'(v) << 25) | 32'h0100_0000);
      chk(irq_lvl[2:0] == v[2:0], "R3 sweep", {29'd0, irq_lvl[2:0]}, v);
      chk(irq_lvl[5:3] == 0, "R11 mid levels", {29'd0, irq_lvl[5:3]}, 0);
    end

    // R7 R8 gated tick train (levels 1..3 stay 111 from last sweep value)
    wr(4'hF, 32'h8100_0000);
    seen_high = 0; prev_low = 0; last_low = -1; lows = 0;
    for (int i = 0; i < 45; i++) begin
      @(negedge clk);
      if (irq_lvl[6]) begin
        seen_high = 1; prev_low = 0;
      end else if (seen_high) begin
        chk(!prev_low, "R7 low lasts one cycle", 0, 1);
        if (last_low >= 0)
          chk(i - last_low == DIV, "R8 tick spacing", i - last_low, DIV);
        last_low = i; lows++; prev_low = 1;
      end
    end
    chk(lows >= 2, "R7 gaps seen", lows, 2);
    chk(irq_lvl[2:0] == 3'b111, "R4 kept across ticks", {29'd0, irq_lvl[2:0]}, 7);

    // R8 no ticks while tick_in low
    @(negedge clk); tick_in = 1'b0;
    repeat (2) @(negedge clk);
    lows = 0;
    for (int i = 0; i < 3 * DIV; i++) begin
      @(negedge clk);
      if (!irq_lvl[6]) lows++;
    end
    chk(lows == 0, "R8 halted prescaler", lows, 0);
    @(negedge clk); tick_in = 1'b1;

    // R6 level-7 drop, then ungated ticks do nothing (R7)
    wr(4'hF, 32'h0100_0000);
    chk(irq_lvl[6] == 1'b0, "R6 level7 cleared", {31'd0, irq_lvl[6]}, 0);
    chk(irq_lvl[2:0] == 3'b111, "R4 kept after R6 write", {29'd0, irq_lvl[2:0]}, 7);
    lows = 0;
    for (int i = 0; i < 3 * DIV; i++) begin
      @(negedge clk);
      if (irq_lvl[6]) lows++;
    end
    chk(lows == 0, "R7 ungated no pulse", lows, 0);

    // Bit 31 alone: clears everything (R5), no ticks (R7)
    wr(4'hF, 32'h8000_0000);
    chk(irq_lvl == 0, "R5 clear with bit31 only", {25'd0, irq_lvl}, 0);
    lows = 0;
    for (int i = 0; i < 3 * DIV; i++) begin
      @(negedge clk);
      if (irq_lvl != 0) lows++;
    end
    chk(lows == 0, "R7 R11 quiet without enable", lows, 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule